// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence Filter

This block watches a stream of conversion results from a light-sensing converter, one result per finished integration period, marked by a single-cycle strobe. It tests each result against a programmable low and high bound. An interrupt is raised only when a programmable number of back-to-back results all fall outside the window. A single stray reading therefore does not disturb the host.

When the filter fires, a sticky status flag is set and an active-low interrupt output is pulled low. Both stay asserted until the host completes a read transfer of the command byte. Software reaches the block through a byte-wide register bus with an address, a write strobe, a read strobe and an end-of-read-transfer strobe. This bus holds the persistence setting, the two bounds, and a read-only copy of the latest result. Read data is registered and appears on the cycle after the read strobe.

Top module: `lux_window_irq`

## Requirements
- R1: After reset, the command byte (address 0x00) reads 0x00, the result bytes (0x02, 0x03) read 0x00, the low bound reads 0x0000 (0x04 and 0x05), the high bound reads 0xFFFF (0x06 and 0x07), and `irq_n` is high.
- R2: Each bound is written and read back one byte at a time: the low bound at 0x04 (bits 7:0) and 0x05 (bits 15:8), the high bound at 0x06 (bits 7:0) and 0x07 (bits 15:8).
- R3: A result is outside the window only when it is strictly below the low bound or strictly above the high bound. A result equal to either bound is inside the window.
- R4: Bits 1:0 of the command byte select how many consecutive outside results are needed to fire: 00 needs 1, 01 needs 4, 10 needs 8, 11 needs 16.
- R5: Any inside result sets the run of consecutive outside results back to zero.
- R6: When the filter fires, bit 2 of the command byte reads 1 and `irq_n` goes low on the clock edge that takes the strobed result. Both hold until they are cleared.
- R7: A pulse on `bus_rd_end` while `bus_addr` is 0x00 clears the status bit and releases `irq_n` high. The same pulse at any other address has no effect.
- R8: If the filter fires in the same cycle as a clearing pulse, the status bit stays 1 and `irq_n` stays low.
- R9: The run count saturates at the selected number. While an excursion continues after a clear, the next outside result fires again.
- R10: Writes to 0x02 and 0x03 are ignored, and so are writes to bit 2 of the command byte. Bits 7:3 of the command byte always read 0.
- R11: A write to the command byte takes effect at once and restarts the run count from zero.
- R12: Address 0x02 returns bits 7:0 and address 0x03 returns bits 15:8 of the most recently strobed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe: a new result is on `conv_data` |
| conv_data | input | 16 | Conversion result |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data appears on `bus_rdata` the next cycle |
| bus_rd_end | input | 1 | End-of-read-transfer strobe for the byte at `bus_addr` |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit result and a 4-bit byte address. With these values all four persistence settings are reachable, including the full 16-result run, and both bytes of every bound and result register can be exercised. Runs are broken one result short of the target to show the count restarting. Equal-to-bound results, a clear that collides with a new firing, and writes aimed at read-only fields are all driven at the ports.

// File: rtl/lux_irq_pkg.sv
package lux_irq_pkg;
  localparam int MAX_NEED = 16;
  localparam int NEED_W   = $clog2(MAX_NEED + 1);

  function automatic logic [NEED_W-1:0] persist_need(input logic [1:0] code);
    case (code)
      2'b00:   return NEED_W'(1);
      2'b01:   return NEED_W'(4);
      2'b10:   return NEED_W'(8);
      default: return NEED_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/lux_irq_regs.sv
module lux_irq_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              status,
  output logic [1:0]        persist,
  output logic              persist_wr,
  output logic [DATA_W-1:0] thr_lo,
  output logic [DATA_W-1:0] thr_hi,
  output logic [DATA_W-1:0] data_q,
  output logic [7:0]        bus_rdata
);
  localparam int NB        = DATA_W / 8;
  localparam int DATA_BASE = 2;
  localparam int LO_BASE   = DATA_BASE + NB;
  localparam int HI_BASE   = LO_BASE + NB;

  logic [7:0] rd_mux;

  assign persist_wr = bus_we && (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (rst)             persist <= 2'b00;
    else if (persist_wr) persist <= bus_wdata[1:0];
  end

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_thr
      always_ff @(posedge clk) begin
        if (rst)
          thr_lo[b*8 +: 8] <= 8'h00;
        else if (bus_we && bus_addr == ADDR_W'(LO_BASE + b))
          thr_lo[b*8 +: 8] <= bus_wdata;
      end
      always_ff @(posedge clk) begin
        if (rst)
          thr_hi[b*8 +: 8] <= 8'hFF;
        else if (bus_we && bus_addr == ADDR_W'(HI_BASE + b))
          thr_hi[b*8 +: 8] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)             data_q <= '0;
    else if (conv_valid) data_q <= conv_data;
  end

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == '0) rd_mux = {5'b00000, status, persist};
    for (int i = 0; i < NB; i++) begin
      if (bus_addr == ADDR_W'(DATA_BASE + i)) rd_mux = data_q[i*8 +: 8];
      if (bus_addr == ADDR_W'(LO_BASE + i))   rd_mux = thr_lo[i*8 +: 8];
      if (bus_addr == ADDR_W'(HI_BASE + i))   rd_mux = thr_hi[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/lux_irq_filter.sv
module lux_irq_filter #(
  parameter int DATA_W = 16,
  parameter int NEED_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [NEED_W-1:0] need,
  input  logic              persist_wr,
  output logic [NEED_W-1:0] cnt_q,
  output logic              outside,
  output logic              hit
);
  logic [NEED_W-1:0] cnt_inc;

  assign outside = (conv_data < thr_lo) || (conv_data > thr_hi);
  assign cnt_inc = (cnt_q >= need) ? need : cnt_q + 1'b1;
  assign hit     = conv_valid && !persist_wr && outside && (cnt_inc == need);

  always_ff @(posedge clk) begin
    if (rst || persist_wr) cnt_q <= '0;
    else if (conv_valid)   cnt_q <= outside ? cnt_inc : '0;
  end
endmodule

// File: rtl/lux_irq_flag.sv
module lux_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic status,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      irq_n  <= 1'b1;
    end else if (hit) begin
      status <= 1'b1;
      irq_n  <= 1'b0;
    end else if (clr) begin
      status <= 1'b0;
      irq_n  <= 1'b1;
    end
  end
endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq
  import lux_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_rd_end,
  output logic [7:0]        bus_rdata,
  output logic              irq_n
);
  logic [1:0]        persist;
  logic              persist_wr;
  logic [DATA_W-1:0] thr_lo, thr_hi, data_q;
  logic [NEED_W-1:0] need, cnt_q;
  logic              outside, hit, clr, status;

  assign need = persist_need(persist);
  assign clr  = bus_rd_end && (bus_addr == '0);

  lux_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .conv_valid(conv_valid),
    .conv_data(conv_data), .status(status), .persist(persist),
    .persist_wr(persist_wr), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .data_q(data_q), .bus_rdata(bus_rdata)
  );

  lux_irq_filter #(.DATA_W(DATA_W), .NEED_W(NEED_W)) i_filter (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .need(need), .persist_wr(persist_wr),
    .cnt_q(cnt_q), .outside(outside), .hit(hit)
  );

  lux_irq_flag i_flag (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .status(status), .irq_n(irq_n)
  );
endmodule

// File: rtl/lux_window_irq_chk.sv
module lux_window_irq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int NEED_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              persist_wr,
  input logic              clr,
  input logic              outside,
  input logic [NEED_W-1:0] need,
  input logic [NEED_W-1:0] cnt_q,
  input logic              status,
  input logic              irq_n,
  input logic [DATA_W-1:0] data_q
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= need); // R4
  AST_RISE_NEEDS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> $past(conv_valid && outside)); // R4
  AST_INSIDE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    conv_valid && !outside |=> cnt_q == '0); // R5
  AST_PIN_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_n == !status); // R6
  AST_CLEAR_ON_END: assert property (@(posedge clk) disable iff (rst)
    clr && !conv_valid |=> !status && irq_n); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    conv_valid && !persist_wr && outside && need == NEED_W'(1) |=> status && !irq_n); // R8
  AST_RESULT_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == ADDR_W'(2) && !conv_valid |=> $stable(data_q)); // R10
  AST_STATUS_NOT_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    persist_wr && status && !clr |=> status); // R10
  AST_PERSIST_WR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    persist_wr |=> cnt_q == '0); // R11
endmodule

bind lux_window_irq lux_window_irq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NEED_W(lux_irq_pkg::NEED_W)
) i_chk (
  .clk(clk), .rst(rst), .conv_valid(conv_valid), .bus_addr(bus_addr),
  .bus_we(bus_we), .persist_wr(persist_wr), .clr(clr), .outside(outside),
  .need(need), .cnt_q(cnt_q), .status(status), .irq_n(irq_n), .data_q(data_q)
);

// File: tb/test_lux_window_irq.sv
`timescale 1ns/1ps
module test_lux_window_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic [15:0] conv_data = '0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_rd_end = 1'b0;
  logic [7:0]  bus_rdata;
  logic        irq_n;

  int vectors = 0;
  int fails = 0;
  logic re_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  lux_window_irq i_lux_window_irq (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rd_end(bus_rd_end), .bus_rdata(bus_rdata),
    .irq_n(irq_n)
  );

  always @(posedge clk) re_seen <= bus_re && !rst;

  // monitor: pops the expected byte for each read strobe taken
  always @(negedge clk) begin
    if (re_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic conv(input logic [15:0] d);
    @(negedge clk);
    conv_data = d; conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic endx(input logic [3:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd_end = 1'b1;
    @(negedge clk);
    bus_rd_end = 1'b0;
  endtask

  task automatic conv_and_clear(input logic [15:0] d);
    @(negedge clk);
    conv_data = d; conv_valid = 1'b1; bus_addr = 4'h0; bus_rd_end = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0; bus_rd_end = 1'b0;
  endtask

  task automatic pin(input logic e, input string t);
    vectors++;
    if (irq_n !== e) begin
      fails++;
      $display("FAIL %s: irq_n actual %b expected %b", t, irq_n, e);
    end
  endtask

  task automatic run_out(input int n);
    for (int i = 0; i < n; i++) conv(16'h0300);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    pin(1'b1, "R1");
    rd(4'h0, 8'h00, "R1"); rd(4'h2, 8'h00, "R1"); rd(4'h3, 8'h00, "R1");
    rd(4'h4, 8'h00, "R1"); rd(4'h5, 8'h00, "R1");
    rd(4'h6, 8'hFF, "R1"); rd(4'h7, 8'hFF, "R1");
    // R2 program window 0x0100..0x0200
    wr(4'h4, 8'h00); wr(4'h5, 8'h01); wr(4'h6, 8'h00); wr(4'h7, 8'h02);
    rd(4'h5, 8'h01, "R2"); rd(4'h7, 8'h02, "R2"); rd(4'h6, 8'h00, "R2");
    // R3 equality is inside
    conv(16'h0100); pin(1'b1, "R3");
    conv(16'h0200); pin(1'b1, "R3");
    // R4/R6 persist 1: single low result fires
    conv(16'h0050); pin(1'b0, "R6");
    rd(4'h0, 8'h04, "R6");
    rd(4'h0, 8'h04, "R6");   // plain read does not clear
    rd(4'h2, 8'h50, "R12"); rd(4'h3, 8'h00, "R12");
    // R7 other address does not clear; address 0 does
    endx(4'h2); pin(1'b0, "R7");
    endx(4'h0); pin(1'b1, "R7");
    rd(4'h0, 8'h00, "R7");
    // R10 write status bit / result bytes ignored
    wr(4'h0, 8'hFC); rd(4'h0, 8'h00, "R10"); pin(1'b1, "R10");
    wr(4'h2, 8'hAA); wr(4'h3, 8'hBB);
    rd(4'h2, 8'h50, "R10"); rd(4'h3, 8'h00, "R10");
    conv(16'h0201); pin(1'b0, "R3");
    wr(4'h0, 8'h00); rd(4'h0, 8'h04, "R10"); pin(1'b0, "R10");
    rd(4'h3, 8'h02, "R12"); rd(4'h2, 8'h01, "R12");
    // R8 set beats clear
    conv_and_clear(16'h0300); pin(1'b0, "R8");
    rd(4'h0, 8'h04, "R8");
    endx(4'h0); pin(1'b1, "R7");
    // R4 persist 4 and R9 saturation
    wr(4'h0, 8'h01);
    run_out(3); pin(1'b1, "R4");
    run_out(1); pin(1'b0, "R4");
    rd(4'h0, 8'h05, "R4");
    endx(4'h0); pin(1'b1, "R9");
    run_out(1); pin(1'b0, "R9");
    endx(4'h0);
    conv(16'h0150); run_out(1); pin(1'b1, "R9");
    // R5 persist 8 with a broken run
    wr(4'h0, 8'h02);
    run_out(7); conv(16'h0180); run_out(7); pin(1'b1, "R5");
    run_out(1); pin(1'b0, "R5");
    endx(4'h0);
    // R4 persist 16
    wr(4'h0, 8'h03);
    run_out(15); pin(1'b1, "R4");
    run_out(1); pin(1'b0, "R4");
    endx(4'h0); pin(1'b1, "R7");
    // R11 persist write restarts run
    wr(4'h0, 8'h01);
    run_out(3); wr(4'h0, 8'h01); run_out(3); pin(1'b1, "R11");
    run_out(1); pin(1'b0, "R11");
    endx(4'h0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule